// File: doc/BRIEF.md
# SPI Interrupt Status and Mask Registers

This block gathers the event flags of an SPI controller and turns them into one interrupt request line. Two of the flags are sticky: a mode-fault pulse from the shift engine, and a transmit-level event that fires when the transmit FIFO occupancy first drops below a programmable threshold. Two others mirror live FIFO conditions: transmit full and receive not empty. Every flag sits in a fixed 7-bit layout. The layout is the same for the status, mask-set, mask-clear and mask-view addresses.

Software clears a sticky flag by writing a one to its status bit. Software enables a source by writing a one to the set address. It disables a source by writing a one to the clear address. Zero bits written to these addresses do nothing. The current mask can be read at its own address. The request line is registered. It is high when any flag that is pending is also enabled.

The register port is a plain single-cycle write and read port. Read data is registered and appears one cycle after the read strobe.

Top module: `spi_irq_regs`

## Requirements
- R1: After reset, the status reads 0, the mask reads 0, the transmit threshold (offset 0x28) reads 1 and `irq` is low.
- R2: `irq` goes high one clock after the status register and the mask register share a set bit. It stays low while the mask is zero, whatever the status.
- R3: Writing to offset 0x08 sets each mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value. The mask reads back at offset 0x10.
- R4: Writing to offset 0x0C clears each mask bit whose write-data bit is 1. The other mask bits keep their value.
- R5: Writing to the status register (offset 0x04) clears each sticky bit whose write-data bit is 1. Writing 0x7F clears every pending sticky flag. The sticky flags are mode fault (bit 1) and TX below threshold (bit 2).
- R6: A `ev_modf` pulse sets status bit 1 on the next clock. If the pulse arrives in the same cycle as a write that clears bit 1, the bit stays set.
- R7: Status bit 3 follows `tx_full` and status bit 4 follows `rx_not_empty`, each one clock later. Writes to the status register do not change these bits.
- R8: Status bit 2 sets when `tx_level` goes from at or above the threshold to below it. It stays set after the level rises again, and it is not set again while the level stays below.
- R9: A write to offset 0x28 loads the threshold from the write data. The threshold reads back at the same offset.
- R10: Status bits 0, 5 and 6 always read 0. Reads of the write-only offsets 0x08 and 0x0C return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Write strobe |
| reg_ren | input | 1 | Read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid one clock after `reg_ren` |
| ev_modf | input | 1 | Mode-fault event pulse |
| tx_full | input | 1 | Transmit FIFO full level |
| rx_not_empty | input | 1 | Receive FIFO not-empty level |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| irq | output | 1 | Interrupt request, registered |

## Verification
The bound checker watches these behaviours on every cycle:
- mask set and clear writes, including the rule that zero bits have no effect;
- clearing of the mode-fault bit by a status write;
- an event winning over a clear in the same cycle;
- the live bits tracking their inputs;
- loading of the threshold;
- `irq` staying low when the mask is zero.

Some behaviours show only in the bench's scenarios, because they depend on a sequence of stimulus:
- the reset values as seen through reads;
- edge-only setting of the below-threshold flag, which stays set once the level recovers;
- zero reads of the write-only and unused bits;
- the exact cycle on which `irq` rises and falls.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NBITS = 7;
  localparam int B_MODF   = 1;
  localparam int B_TXLOW  = 2;
  localparam int B_TXFULL = 3;
  localparam int B_RXNE   = 4;
  localparam logic [NBITS-1:0] STICKY_BITS = 7'b0000110;
  localparam logic [NBITS-1:0] LIVE_BITS   = 7'b0011000;
  localparam logic [7:0] OFF_STATUS = 8'h04;
  localparam logic [7:0] OFF_SET    = 8'h08;
  localparam logic [7:0] OFF_CLR    = 8'h0C;
  localparam logic [7:0] OFF_MASK   = 8'h10;
  localparam logic [7:0] OFF_THR    = 8'h28;
  typedef enum logic [2:0] {
    SEL_NONE, SEL_STATUS, SEL_SET, SEL_CLR, SEL_MASK, SEL_THR
  } reg_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NBITS = 7,
  parameter logic [NBITS-1:0] STICKY = '0,
  parameter logic [NBITS-1:0] LIVE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] set_vec,
  input  logic [NBITS-1:0] live_vec,
  input  logic [NBITS-1:0] clr_vec,
  output logic [NBITS-1:0] status
);
  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    if (STICKY[i]) begin : g_sticky
      always_ff @(posedge clk) begin
        if (rst) status[i] <= 1'b0;
        else     status[i] <= set_vec[i] | (status[i] & ~clr_vec[i]);
      end
    end else if (LIVE[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (rst) status[i] <= 1'b0;
        else     status[i] <= live_vec[i];
      end
    end else begin : g_none
      assign status[i] = 1'b0;
    end
  end

  logic unused_inputs;
  assign unused_inputs = ^{set_vec & ~STICKY, live_vec & ~LIVE, clr_vec & ~STICKY};
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int NBITS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [NBITS-1:0] bits,
  output logic [NBITS-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)         mask <= '0;
    else if (set_we) mask <= mask | bits;
    else if (clr_we) mask <= mask & ~bits;
  end
endmodule

// File: rtl/irq_watermark.sv
module irq_watermark #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             thr_we,
  input  logic [LVL_W-1:0] thr_wdata,
  input  logic [LVL_W-1:0] tx_level,
  output logic [LVL_W-1:0] thr_q,
  output logic             low_event
);
  logic below, below_q;

  assign below     = tx_level < thr_q;
  assign low_event = below & ~below_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q   <= LVL_W'(1);
      below_q <= 1'b1;
    end else begin
      if (thr_we) thr_q <= thr_wdata;
      below_q <= below;
    end
  end
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int LVL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wen,
  input  logic              reg_ren,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_modf,
  input  logic              tx_full,
  input  logic              rx_not_empty,
  input  logic [LVL_W-1:0]  tx_level,
  output logic              irq
);
  reg_sel_e         sel;
  logic [NBITS-1:0] wbits, set_vec, live_vec, clr_vec;
  logic [NBITS-1:0] status_q, mask_q;
  logic [LVL_W-1:0] thr_q;
  logic             low_event;

  always_comb begin
    sel = SEL_NONE;
    if      (reg_addr == OFF_STATUS[ADDR_W-1:0]) sel = SEL_STATUS;
    else if (reg_addr == OFF_SET[ADDR_W-1:0])    sel = SEL_SET;
    else if (reg_addr == OFF_CLR[ADDR_W-1:0])    sel = SEL_CLR;
    else if (reg_addr == OFF_MASK[ADDR_W-1:0])   sel = SEL_MASK;
    else if (reg_addr == OFF_THR[ADDR_W-1:0])    sel = SEL_THR;
  end

  assign wbits = reg_wdata[NBITS-1:0];

  always_comb begin
    set_vec           = '0;
    set_vec[B_MODF]   = ev_modf;
    set_vec[B_TXLOW]  = low_event;
    live_vec          = '0;
    live_vec[B_TXFULL] = tx_full;
    live_vec[B_RXNE]   = rx_not_empty;
    clr_vec = (reg_wen && sel == SEL_STATUS) ? wbits : '0;
  end

  irq_status_bank #(.NBITS(NBITS), .STICKY(STICKY_BITS), .LIVE(LIVE_BITS)) u_status (
    .clk(clk), .rst(rst), .set_vec(set_vec), .live_vec(live_vec),
    .clr_vec(clr_vec), .status(status_q)
  );

  irq_mask_bank #(.NBITS(NBITS)) u_mask (
    .clk(clk), .rst(rst),
    .set_we(reg_wen && sel == SEL_SET),
    .clr_we(reg_wen && sel == SEL_CLR),
    .bits(wbits), .mask(mask_q)
  );

  irq_watermark #(.LVL_W(LVL_W)) u_wm (
    .clk(clk), .rst(rst),
    .thr_we(reg_wen && sel == SEL_THR),
    .thr_wdata(reg_wdata[LVL_W-1:0]),
    .tx_level(tx_level), .thr_q(thr_q), .low_event(low_event)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= |(status_q & mask_q);
      if (reg_ren) begin
        unique case (sel)
          SEL_STATUS: reg_rdata <= DATA_W'(status_q);
          SEL_MASK:   reg_rdata <= DATA_W'(mask_q);
          SEL_THR:    reg_rdata <= DATA_W'(thr_q);
          default:    reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_irq_regs_chk.sv
module spi_irq_regs_chk
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int LVL_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wen,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              ev_modf,
  input logic              tx_full,
  input logic              rx_not_empty,
  input logic              low_event,
  input logic [NBITS-1:0]  status_q,
  input logic [NBITS-1:0]  mask_q,
  input logic [LVL_W-1:0]  thr_q,
  input logic              irq
);
  logic wr_status, wr_set, wr_clr, wr_thr;
  assign wr_status = reg_wen && reg_addr == OFF_STATUS[ADDR_W-1:0];
  assign wr_set    = reg_wen && reg_addr == OFF_SET[ADDR_W-1:0];
  assign wr_clr    = reg_wen && reg_addr == OFF_CLR[ADDR_W-1:0];
  assign wr_thr    = reg_wen && reg_addr == OFF_THR[ADDR_W-1:0];

  p_masked_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq);
  p_set_bits_r3: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> ((mask_q & $past(reg_wdata[NBITS-1:0])) == $past(reg_wdata[NBITS-1:0]))
               && ((mask_q & $past(mask_q)) == $past(mask_q)));
  p_clr_bits_r4: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> ((mask_q & $past(reg_wdata[NBITS-1:0])) == '0)
               && ((mask_q | $past(reg_wdata[NBITS-1:0])) == ($past(mask_q) | $past(reg_wdata[NBITS-1:0]))));
  p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_status && reg_wdata[B_MODF] && !ev_modf) |=> !status_q[B_MODF]);
  p_event_wins_r6: assert property (@(posedge clk) disable iff (rst)
    ev_modf |=> status_q[B_MODF]);
  p_live_full_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> status_q[B_TXFULL] == $past(tx_full));
  p_live_rxne_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> status_q[B_RXNE] == $past(rx_not_empty));
  p_low_sets_r8: assert property (@(posedge clk) disable iff (rst)
    low_event |=> status_q[B_TXLOW]);
  p_thr_load_r9: assert property (@(posedge clk) disable iff (rst)
    wr_thr |=> thr_q == $past(reg_wdata[LVL_W-1:0]));
endmodule

bind spi_irq_regs spi_irq_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .ev_modf(ev_modf), .tx_full(tx_full), .rx_not_empty(rx_not_empty),
  .low_event(low_event), .status_q(status_q), .mask_q(mask_q), .thr_q(thr_q), .irq(irq)
);

// File: tb/sim_spi_irq_regs.sv
module sim_spi_irq_regs;
  localparam int ADDR_W = 6, DATA_W = 8, LVL_W = 8;
  localparam logic [ADDR_W-1:0] A_ST = 6'h04, A_SET = 6'h08, A_CLR = 6'h0C,
                                A_MSK = 6'h10, A_THR = 6'h28;

  logic clk = 0, rst = 1;
  logic reg_wen = 0, reg_ren = 0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0, reg_rdata;
  logic ev_modf = 0, tx_full = 0, rx_not_empty = 0;
  logic [LVL_W-1:0] tx_level = 8'd8;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W)) u0 (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_ren(reg_ren), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_modf(ev_modf), .tx_full(tx_full),
    .rx_not_empty(rx_not_empty), .tx_level(tx_level), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FIAL-free %s", ""); 
    end
  endtask

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    reg_wen = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 0; reg_wdata = '0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    reg_ren = 1; reg_addr = a;
    @(negedge clk);
    reg_ren = 0;
    d = reg_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [DATA_W-1:0] d;
    rd(A_ST, d);  cmp("R1 status", d, 0);
    rd(A_MSK, d); cmp("R1 mask", d, 0);
    rd(A_THR, d); cmp("R1 threshold", d, 1);
    cmp("R1 irq", irq, 0);
  endtask

  task automatic t_mask;
    logic [DATA_W-1:0] d;
    wr(A_SET, 8'h06); rd(A_MSK, d); cmp("R3 set", d, 8'h06);
    wr(A_SET, 8'h10); rd(A_MSK, d); cmp("R3 zeros keep", d, 8'h16);
    wr(A_CLR, 8'h04); rd(A_MSK, d); cmp("R4 clear", d, 8'h12);
    wr(A_CLR, 8'h00); rd(A_MSK, d); cmp("R4 zeros keep", d, 8'h12);
    rd(A_SET, d); cmp("R10 set addr reads 0", d, 0);
    rd(A_CLR, d); cmp("R10 clr addr reads 0", d, 0);
  endtask

  task automatic t_modf;
    logic [DATA_W-1:0] d;
    ev_modf = 1; @(negedge clk); ev_modf = 0;
    cmp("R6 irq not yet", irq, 0);
    @(negedge clk);
    cmp("R2 irq rises", irq, 1);
    rd(A_ST, d); cmp("R6 status bit1", d, 8'h02);
    wr(A_ST, 8'h7F);
    cmp("R5 irq still high", irq, 1);
    @(negedge clk);
    cmp("R5 irq falls", irq, 0);
    rd(A_ST, d); cmp("R5 cleared", d, 0);
    reg_wen = 1; reg_addr = A_ST; reg_wdata = 8'h02; ev_modf = 1;
    @(negedge clk);
    reg_wen = 0; ev_modf = 0;
    rd(A_ST, d); cmp("R6 event beats clear", d, 8'h02);
    wr(A_ST, 8'h02);
  endtask

  task automatic t_live;
    logic [DATA_W-1:0] d;
    rx_not_empty = 1; tx_full = 1;
    @(negedge clk);
    rd(A_ST, d); cmp("R7 live bits", d, 8'h18);
    cmp("R2 irq from rxne", irq, 1);
    wr(A_ST, 8'h7F);
    rd(A_ST, d); cmp("R7 write ignored", d, 8'h18);
    rx_not_empty = 0; tx_full = 0;
    @(negedge clk);
    rd(A_ST, d); cmp("R7 live drop", d, 0);
    cmp("R2 irq drop", irq, 0);
  endtask

  task automatic t_watermark;
    logic [DATA_W-1:0] d;
    wr(A_THR, 8'd4); rd(A_THR, d); cmp("R9 threshold", d, 4);
    tx_level = 8'd3; @(negedge clk);
    rd(A_ST, d); cmp("R8 below sets", d, 8'h04);
    tx_level = 8'd8; idle(2);
    rd(A_ST, d); cmp("R8 sticky", d, 8'h04);
    wr(A_ST, 8'h04);
    rd(A_ST, d); cmp("R8 cleared", d, 0);
    tx_level = 8'd2; @(negedge clk);
    wr(A_ST, 8'h04);
    idle(2);
    rd(A_ST, d); cmp("R8 no reset while low", d, 0);
    tx_level = 8'd8; @(negedge clk);
  endtask

  task automatic t_masked_off;
    logic [DATA_W-1:0] d;
    wr(A_CLR, 8'h7F);
    ev_modf = 1; rx_not_empty = 1; @(negedge clk);
    ev_modf = 0; idle(2);
    cmp("R2 masked irq low", irq, 0);
    rd(A_ST, d); cmp("R10 unused bits zero", d & 8'h61, 0);
    rx_not_empty = 0;
    wr(A_ST, 8'h7F);
  endtask

  initial begin
    idle(3);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_mask;
    t_modf;
    t_live;
    t_watermark;
    t_masked_off;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule